// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Encoder and Corrector

This block guards 8-bit data words with a 12-bit Hamming code that corrects any single flipped bit. The write-side encoder takes a data byte and produces a 12-bit codeword. The byte is spread over the positions that are not powers of two. Four parity bits sit at positions 1, 2, 4 and 8, and each one makes its group of covered positions even.

The read-side corrector takes a 12-bit word back from storage. It recomputes the four checks and forms a syndrome that directly names the 1-based position of a single bad bit. It then flips that bit and returns the repaired data byte, the syndrome and two flags. A syndrome of 13, 14 or 15 cannot come from one error. Such a word is flagged as uncorrectable and its data field is passed through unchanged.

Both paths are registered with one cycle of latency and a valid strobe. The two paths are independent, so a write and a read can be handled in the same cycle. The block sits between a data source and a memory word and stores nothing itself.

Top module: `hamming_sec_unit`

## Requirements
- R1: Codeword bit index i holds position i+1. Data bit k (k = 0..7) is placed at positions 3, 5, 6, 7, 9, 10, 11, 12 respectively, so encoding 0x01 gives codeword 12'h007.
- R2: Each parity bit at position 2^j (j = 0..3) makes even the XOR over all positions whose index has bit j set.
- R3: `enc_valid_o` is high exactly one cycle after `enc_valid_i`. `enc_code_o` updates only on that cycle and otherwise holds its value.
- R4: A received word with all checks even gives syndrome 0, the data field on `dec_data_o`, and both flags low.
- R5: A single error at any position 1..12 gives a syndrome equal to that position, raises `dec_corrected_o` and returns the original data. An error at position 1 gives 4'b0001 and one at position 5 gives 4'b0101.
- R6: An error on a parity position (1, 2, 4 or 8) is reported and corrected like any other, and the data byte is returned unchanged.
- R7: A syndrome of 13, 14 or 15 raises `dec_uncorr_o`, keeps `dec_corrected_o` low, and returns the received data field without modification.
- R8: `dec_valid_o` is high exactly one cycle after `dec_valid_i`, and the decode outputs otherwise hold their values.
- R9: During and after reset, before any strobe, both valid outputs are low and all data, code, syndrome and flag outputs are zero.
- R10: An encode and a decode presented in the same cycle are both completed correctly in the next cycle, without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | 8 | Data byte to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 12 | Encoded 12-bit word |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_code_i | input | 12 | Received 12-bit word |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Corrected data byte |
| dec_syndrome_o | output | 4 | Syndrome (position of the bad bit, 0 if clean) |
| dec_corrected_o | output | 1 | A single error was corrected |
| dec_uncorr_o | output | 1 | Syndrome out of range (13..15) |

## Verification
An encode and a decode can fall in the same cycle, because the two paths share only clock and reset. The bench presents both strobes together in many cycles. In those cycles it decodes the previous codeword with an injected error while a new byte is encoded. Both results are judged in the next cycle against a behavioural model that forms the syndrome by XOR-ing the index of every set bit. The bench also runs cycles with only one strobe or none, to show that each result register holds its value.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int CODE_W = DATA_W + PAR_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } hsec_state_e;

    // 1-based codeword position of data bit idx: the idx-th non power of two
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
    parameter int DW = hsec_pkg::DATA_W,
    parameter int PW = hsec_pkg::PAR_W,
    localparam int CW = DW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [CW-1:0] code_o
);
    logic [CW-1:0] placed;
    logic [CW-1:0] full;

    always_comb begin
        placed = '0;
        for (int i = 0; i < DW; i++) begin
            placed[hsec_pkg::data_pos(i) - 1] = data_i[i];
        end
        full = placed;
        for (int j = 0; j < PW; j++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW; p++) begin
                if (((p >> j) & 1) == 1) par = par ^ placed[p-1];
            end
            full[(1 << j) - 1] = par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) code_o <= full;
        end
    end
endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
    parameter int DW = hsec_pkg::DATA_W,
    parameter int PW = hsec_pkg::PAR_W,
    localparam int CW = DW + PW
) (
    input  logic [CW-1:0] code_i,
    output logic [PW-1:0] syn_o
);
    always_comb begin
        syn_o = '0;
        for (int j = 0; j < PW; j++) begin
            for (int p = 1; p <= CW; p++) begin
                if (((p >> j) & 1) == 1) syn_o[j] = syn_o[j] ^ code_i[p-1];
            end
        end
    end
endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
    parameter int DW = hsec_pkg::DATA_W,
    parameter int PW = hsec_pkg::PAR_W,
    localparam int CW = DW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [CW-1:0] code_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic [PW-1:0] syn_o,
    output logic          corrected_o,
    output logic          uncorr_o
);
    import hsec_pkg::*;

    logic [PW-1:0]  syn;
    hsec_state_e    state;
    logic [CW-1:0]  fixed;
    logic [DW-1:0]  data_n;
    logic           corr_n;
    logic           bad_n;

    hsec_syndrome #(.DW(DW), .PW(PW)) i_syn (
        .code_i (code_i),
        .syn_o  (syn)
    );

    always_comb begin
        if (syn == '0)                  state = ST_CLEAN;
        else if (int'(syn) <= CW)       state = ST_FIXED;
        else                            state = ST_BAD;
    end

    always_comb begin
        fixed  = code_i;
        corr_n = 1'b0;
        bad_n  = 1'b0;
        unique case (state)
            ST_CLEAN: ;
            ST_FIXED: begin
                fixed[int'(syn) - 1] = ~code_i[int'(syn) - 1];
                corr_n = 1'b1;
            end
            ST_BAD:   bad_n = 1'b1;
            default:  bad_n = 1'b1;
        endcase
        for (int i = 0; i < DW; i++) begin
            data_n[i] = fixed[data_pos(i) - 1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            data_o      <= '0;
            syn_o       <= '0;
            corrected_o <= 1'b0;
            uncorr_o    <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o      <= data_n;
                syn_o       <= syn;
                corrected_o <= corr_n;
                uncorr_o    <= bad_n;
            end
        end
    end
endmodule

// File: rtl/hamming_sec_unit.sv
module hamming_sec_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enc_valid_i,
    input  logic [7:0]  enc_data_i,
    output logic        enc_valid_o,
    output logic [11:0] enc_code_o,
    input  logic        dec_valid_i,
    input  logic [11:0] dec_code_i,
    output logic        dec_valid_o,
    output logic [7:0]  dec_data_o,
    output logic [3:0]  dec_syndrome_o,
    output logic        dec_corrected_o,
    output logic        dec_uncorr_o
);
    localparam int DW = hsec_pkg::DATA_W;
    localparam int PW = hsec_pkg::PAR_W;

    hsec_encoder #(.DW(DW), .PW(PW)) i_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    hsec_corrector #(.DW(DW), .PW(PW)) i_cor (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (dec_valid_i),
        .code_i      (dec_code_i),
        .valid_o     (dec_valid_o),
        .data_o      (dec_data_o),
        .syn_o       (dec_syndrome_o),
        .corrected_o (dec_corrected_o),
        .uncorr_o    (dec_uncorr_o)
    );
endmodule

// File: rtl/hsec_checker.sv
module hsec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        enc_valid_i,
    input logic        enc_valid_o,
    input logic [11:0] enc_code_o,
    input logic        dec_valid_i,
    input logic        dec_valid_o,
    input logic [3:0]  dec_syndrome_o,
    input logic        dec_corrected_o,
    input logic        dec_uncorr_o
);
    // R3: encoder strobe appears one cycle later
    p_enc_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
    p_enc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));

    // R8: decoder strobe appears one cycle later
    p_dec_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);
    p_dec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);

    // R2: every group of an emitted codeword is even (masks for 12-bit word)
    p_even_groups_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> ((^(enc_code_o & 12'h555)) == 1'b0 &&
                         (^(enc_code_o & 12'h666)) == 1'b0 &&
                         (^(enc_code_o & 12'h878)) == 1'b0 &&
                         (^(enc_code_o & 12'hF80)) == 1'b0));

    // R4: clean syndrome raises no flag
    p_clean_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o == 4'd0) |-> (!dec_corrected_o && !dec_uncorr_o));

    // R5: in-range syndrome means a correction
    p_fix_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o != 4'd0 && dec_syndrome_o <= 4'd12) |-> dec_corrected_o);

    // R7: out-of-range syndrome means uncorrectable, never both flags
    p_bad_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o > 4'd12) |-> (dec_uncorr_o && !dec_corrected_o));
endmodule

bind hamming_sec_unit hsec_checker i_hsec_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .enc_valid_i     (enc_valid_i),
    .enc_valid_o     (enc_valid_o),
    .enc_code_o      (enc_code_o),
    .dec_valid_i     (dec_valid_i),
    .dec_valid_o     (dec_valid_o),
    .dec_syndrome_o  (dec_syndrome_o),
    .dec_corrected_o (dec_corrected_o),
    .dec_uncorr_o    (dec_uncorr_o)
);

// File: tb/test_hamming_sec_unit.sv
`timescale 1ns/1ps
module test_hamming_sec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic        enc_valid_o;
    logic [11:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [11:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic [3:0]  dec_syndrome_o;
    logic        dec_corrected_o;
    logic        dec_uncorr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state (held between strobes)
    logic [11:0] m_code = '0;
    logic [7:0]  m_data = '0;
    logic [3:0]  m_syn  = '0;
    logic        m_fix  = 1'b0;
    logic        m_bad  = 1'b0;

    always #5 clk = ~clk;

    hamming_sec_unit i_hamming_sec_unit (.*);

    function automatic bit is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [11:0] ref_encode(logic [7:0] d);
        logic [11:0] w;
        int k;
        w = '0;
        k = 0;
        for (int p = 1; p <= 12; p++) begin
            if (!is_pow2(p)) begin
                w[p-1] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 4; j++) begin
            int ones;
            ones = 0;
            for (int p = 1; p <= 12; p++)
                if (((p >> j) & 1) == 1 && w[p-1]) ones++;
            w[(1 << j) - 1] = ones[0];
        end
        return w;
    endfunction

    function automatic logic [7:0] ref_field(logic [11:0] w);
        logic [7:0] d;
        int k;
        k = 0;
        d = '0;
        for (int p = 1; p <= 12; p++) begin
            if (!is_pow2(p)) begin
                d[k] = w[p-1];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [3:0] ref_syn(logic [11:0] w);
        int s;
        s = 0;
        for (int p = 1; p <= 12; p++) if (w[p-1]) s = s ^ p;
        return 4'(s);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare all outputs just after the edge
    task automatic cyc(string tag, bit ev, logic [7:0] ed, bit dv, logic [11:0] dc);
        @(negedge clk);
        enc_valid_i = ev;
        enc_data_i  = ed;
        dec_valid_i = dv;
        dec_code_i  = dc;
        @(posedge clk);
        #1;
        if (ev) m_code = ref_encode(ed);
        if (dv) begin
            logic [11:0] w;
            w = dc;
            m_syn = ref_syn(dc);
            m_fix = (m_syn != 0) && (m_syn <= 12);
            m_bad = (m_syn > 12);
            if (m_fix) w[m_syn - 1] = ~w[m_syn - 1];
            m_data = ref_field(w);
        end
        chk(tag, "enc_valid", int'(enc_valid_o), int'(ev));
        chk(tag, "enc_code", int'(enc_code_o), int'(m_code));
        chk(tag, "dec_valid", int'(dec_valid_o), int'(dv));
        chk(tag, "dec_data", int'(dec_data_o), int'(m_data));
        chk(tag, "dec_syn", int'(dec_syndrome_o), int'(m_syn));
        chk(tag, "dec_fix", int'(dec_corrected_o), int'(m_fix));
        chk(tag, "dec_bad", int'(dec_uncorr_o), int'(m_bad));
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev_d;
        logic [11:0] w;
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "enc_valid", int'(enc_valid_o), 0);
        chk("R9", "enc_code", int'(enc_code_o), 0);
        chk("R9", "dec_valid", int'(dec_valid_o), 0);
        chk("R9", "dec_data", int'(dec_data_o), 0);
        chk("R9", "dec_syn", int'(dec_syndrome_o), 0);
        chk("R9", "flags", int'({dec_corrected_o, dec_uncorr_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R9", 0, 8'h00, 0, 12'h000);

        // R1: literal placement of data bit 0
        cyc("R1", 1, 8'h01, 0, 12'h000);
        chk("R1", "code_of_01", int'(enc_code_o), 12'h007);
        // R2/R1 several patterns, R4 clean decode of each
        foreach (prev_d[i]) begin
            logic [7:0] d;
            d = 8'h01 << i;
            cyc("R2", 1, d, 0, 12'h000);
            cyc("R4", 0, 8'h00, 1, ref_encode(d));
        end
        cyc("R2", 1, 8'hFF, 1, ref_encode(8'hA5));
        cyc("R4", 1, 8'hC4, 1, ref_encode(8'h00));
        // R3/R8 idle cycles: outputs hold
        cyc("R3", 0, 8'h5A, 0, 12'hFFF);
        cyc("R8", 0, 8'h00, 0, 12'h000);

        // R5: documented syndromes
        w = ref_encode(8'hC4);
        cyc("R5", 0, 8'h00, 1, w ^ 12'h001);
        chk("R5", "syn_pos1", int'(dec_syndrome_o), 1);
        cyc("R5", 0, 8'h00, 1, w ^ 12'h010);
        chk("R5", "syn_pos5", int'(dec_syndrome_o), 5);
        chk("R5", "data_pos5", int'(dec_data_o), 8'hC4);

        // R5/R6/R10: every single-bit error while encoding in the same cycle
        prev_d = 8'h3C;
        for (int round = 0; round < 20; round++) begin
            for (int p = 1; p <= 12; p++) begin
                logic [7:0] nd;
                nd = 8'((round * 37 + p * 11) ^ 8'h96);
                w = ref_encode(prev_d) ^ (12'h001 << (p - 1));
                cyc(is_pow2(p) ? "R6" : "R10", 1, nd, 1, w);
                chk("R5", "recovered", int'(dec_data_o), int'(prev_d));
                prev_d = nd;
            end
        end

        // R7: double errors that land outside the word
        w = ref_encode(8'h6B);
        cyc("R7", 0, 8'h00, 1, w ^ 12'h801);
        chk("R7", "syn13", int'(dec_syndrome_o), 13);
        chk("R7", "raw13", int'(dec_data_o), int'(ref_field(w ^ 12'h801)));
        cyc("R7", 1, 8'h11, 1, w ^ 12'h802);
        chk("R7", "syn14", int'(dec_syndrome_o), 14);
        cyc("R7", 0, 8'h00, 1, w ^ 12'h804);
        chk("R7", "syn15", int'(dec_syndrome_o), 15);
        chk("R7", "uncorr", int'(dec_uncorr_o), 1);
        cyc("R8", 0, 8'h00, 0, 12'h000);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule